// File: doc/BRIEF.md
# Barrel Issue Scheduler with Wait Tracking

This block chooses, once per clock, which hardware thread of a multi-threaded core issues into the execution pipeline. Every thread carries two flags, in-use and waiting, plus a small FIFO of prefetched instructions. A thread is runnable when it is in use, is not waiting, and has no instruction still travelling through the pipeline. The scheduler rotates over the runnable threads. A selected thread issues the head of its FIFO. If that FIFO is empty, the thread issues a fetch no-op, whose job is to pull more instructions into it.

Resource logic parks a thread when it stalls on a synchroniser, a channel, a port, a timer or an event. It wakes the thread again with a resume pulse. Threads are started and stopped by pulse masks. Memory returns fetched words through a single fill port. When no in-use thread is able to run, the block raises a power-down request so that the core can idle until an event arrives.

Top module: `barrel_issue_sched`

## Requirements
- R1: While reset is held, every issue output is 0 and `pwr_down` is 0. After reset only thread 0 is in use and nothing waits. The first edge after reset issues thread 0 as a fetch no-op.
- R2: At each edge the issued thread is the first runnable thread found by scanning upward from the last issued thread, wrapping from NT-1 to 0. Right after reset, the last issued thread counts as NT-1.
- R3: A thread issued at edge k cannot issue again before edge k+PIPE. Only one instruction per thread is ever in the pipeline.
- R4: With n runnable threads and n ≥ PIPE, every window of n·m consecutive issue slots holds exactly m issues from each thread.
- R5: A `wait_req` bit for an in-use thread sets that thread's waiting flag at the clock edge. From the next edge onward the thread does not issue.
- R6: A `resume_req` bit clears the waiting flag at the edge, and the thread can be selected from the following edge. When resume and wait arrive for the same thread in the same cycle, the resume wins.
- R7: A `start_req` bit marks a thread in use and not waiting, and empties its FIFO. A `stop_req` bit clears in-use and waiting. If both arrive together, start wins. A thread that is not in use never issues.
- R8: When the selected thread's FIFO holds words, the oldest word is issued with `issue_nop`=0. When the FIFO is empty, `issue_nop`=1 and `issue_instr`=0.
- R9: Each FIFO holds DEPTH words. A fill that targets a full FIFO, or a thread being started in the same cycle, is dropped, and the words already stored keep their order.
- R10: When no thread can be selected at an edge, `issue_valid`, `issue_nop`, `issue_tid` and `issue_instr` are all 0 after that edge.
- R11: `pwr_down` is 1 exactly when no in-use thread is free of its waiting flag. It is taken from the registered flags, so it changes just after the edge that updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | NT | One bit per thread: bring the thread into use |
| stop_req | input | NT | One bit per thread: release the thread |
| wait_req | input | NT | One bit per thread: park the thread on a resource condition |
| resume_req | input | NT | One bit per thread: the awaited condition has been met |
| fill_valid | input | 1 | A fetched instruction word is present |
| fill_tid | input | $clog2(NT) | Thread whose FIFO receives the word |
| fill_instr | input | IW | Fetched instruction word |
| issue_valid | output | 1 | An issue slot was used at the last edge |
| issue_tid | output | $clog2(NT) | Thread that issued |
| issue_nop | output | 1 | The issue is a fetch no-op |
| issue_instr | output | IW | Issued instruction word; 0 for a no-op or an idle slot |
| pwr_down | output | 1 | Every in-use thread is waiting |

## Verification
The assertions assume that `fill_tid` always names an existing thread. They also assume that request masks are held for only one cycle at a time, so that a resume or a start seen at one edge is not overridden at the next. The bench drives every mask for exactly one cycle and only ever fills threads 0 to 7. It updates inputs on the falling edge, so each request is seen by exactly one rising edge. Every overlap it creates on purpose (resume together with wait, a fill into a full FIFO) is a case whose result the requirements define.

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched #(
  parameter int NT    = 8,
  parameter int DEPTH = 4,
  parameter int PIPE  = 4,
  parameter int IW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NT-1:0]         start_req,
  input  logic [NT-1:0]         stop_req,
  input  logic [NT-1:0]         wait_req,
  input  logic [NT-1:0]         resume_req,
  input  logic                  fill_valid,
  input  logic [$clog2(NT)-1:0] fill_tid,
  input  logic [IW-1:0]         fill_instr,
  output logic                  issue_valid,
  output logic [$clog2(NT)-1:0] issue_tid,
  output logic                  issue_nop,
  output logic [IW-1:0]         issue_instr,
  output logic                  pwr_down
);
  localparam int TW  = $clog2(NT);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int CLW = $clog2(PIPE + 1);

  logic [NT-1:0] in_use, waiting, elig, pop_t, push_t;
  logic [TW-1:0] last, sel;
  logic [TW:0]   nx;
  logic          found, pop, push;
  logic [CLW-1:0] cool [NT];
  logic [AW-1:0]  rdp  [NT];
  logic [AW-1:0]  wrp  [NT];
  logic [CW-1:0]  cnt  [NT];
  logic [IW-1:0]  mem  [NT][DEPTH];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb
    for (int t = 0; t < NT; t++)
      elig[t] = in_use[t] & ~waiting[t] & (cool[t] == '0);

  always_comb begin
    found = 1'b0;
    sel   = '0;
    nx    = '0;
    for (int k = 1; k <= NT; k++) begin
      nx = {1'b0, last} + (TW+1)'(k);
      if (nx >= (TW+1)'(NT)) nx = nx - (TW+1)'(NT);
      if (!found && elig[nx[TW-1:0]]) begin
        found = 1'b1;
        sel   = nx[TW-1:0];
      end
    end
  end

  assign pop      = found && (cnt[sel] != '0);
  assign push     = fill_valid && (cnt[fill_tid] < CW'(DEPTH)) && !start_req[fill_tid];
  assign pwr_down = ~|(in_use & ~waiting);

  always_comb
    for (int t = 0; t < NT; t++) begin
      pop_t[t]  = pop  && (sel == TW'(t));
      push_t[t] = push && (fill_tid == TW'(t));
    end

  always_ff @(posedge clk)
    if (push) mem[fill_tid][wrp[fill_tid]] <= fill_instr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_use      <= NT'(1);
      waiting     <= '0;
      last        <= TW'(NT - 1);
      issue_valid <= 1'b0;
      issue_tid   <= '0;
      issue_nop   <= 1'b0;
      issue_instr <= '0;
      for (int t = 0; t < NT; t++) begin
        cool[t] <= '0;
        rdp[t]  <= '0;
        wrp[t]  <= '0;
        cnt[t]  <= '0;
      end
    end else begin
      issue_valid <= found;
      issue_tid   <= found ? sel : '0;
      issue_nop   <= found && !pop;
      issue_instr <= pop ? mem[sel][rdp[sel]] : '0;
      if (found) last <= sel;
      for (int t = 0; t < NT; t++) begin
        if (found && sel == TW'(t)) cool[t] <= CLW'(PIPE - 1);
        else if (cool[t] != '0)     cool[t] <= cool[t] - 1'b1;

        if (start_req[t]) begin
          in_use[t]  <= 1'b1;
          waiting[t] <= 1'b0;
        end else if (stop_req[t]) begin
          in_use[t]  <= 1'b0;
          waiting[t] <= 1'b0;
        end else if (resume_req[t]) begin
          waiting[t] <= 1'b0;
        end else if (wait_req[t] && in_use[t]) begin
          waiting[t] <= 1'b1;
        end

        if (start_req[t]) begin
          rdp[t] <= '0;
          wrp[t] <= '0;
          cnt[t] <= '0;
        end else begin
          if (pop_t[t])  rdp[t] <= bump(rdp[t]);
          if (push_t[t]) wrp[t] <= bump(wrp[t]);
          if (pop_t[t] && !push_t[t])      cnt[t] <= cnt[t] - 1'b1;
          else if (push_t[t] && !pop_t[t]) cnt[t] <= cnt[t] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/barrel_issue_chk.sv
module barrel_issue_chk #(
  parameter int NT   = 8,
  parameter int PIPE = 4,
  parameter int IW   = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NT-1:0]         start_req,
  input logic [NT-1:0]         resume_req,
  input logic [NT-1:0]         in_use,
  input logic [NT-1:0]         waiting,
  input logic                  issue_valid,
  input logic [$clog2(NT)-1:0] issue_tid,
  input logic                  issue_nop,
  input logic [IW-1:0]         issue_instr,
  input logic                  pwr_down
);
  logic [NT-1:0] ran_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ran_q <= '0;
    else        ran_q <= in_use & ~waiting;

  a_r5_runnable_only: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ran_q[issue_tid]);

  a_r11_sleep_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !issue_valid);

  a_r8_nop_has_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    issue_nop |-> (issue_valid && issue_instr == '0));

  a_r10_idle_slot_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (!issue_nop && issue_tid == '0 && issue_instr == '0));

  if (PIPE > 1) begin : g_gap
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |=> !(issue_valid && issue_tid == $past(issue_tid)));
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    a_r6_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
      resume_req[t] |=> !waiting[t]);
    a_r7_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
      start_req[t] |=> (in_use[t] && !waiting[t]));
  end
endmodule

bind barrel_issue_sched barrel_issue_chk #(.NT(NT), .PIPE(PIPE), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .resume_req(resume_req),
  .in_use(in_use), .waiting(waiting), .issue_valid(issue_valid),
  .issue_tid(issue_tid), .issue_nop(issue_nop), .issue_instr(issue_instr),
  .pwr_down(pwr_down)
);

// File: tb/sim_barrel_issue_sched.sv
module sim_barrel_issue_sched;
  localparam int NT = 8, DEPTH = 4, PIPE = 4, IW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0] start_req = '0, stop_req = '0, wait_req = '0, resume_req = '0;
  logic fill_valid = 1'b0;
  logic [2:0] fill_tid = '0;
  logic [IW-1:0] fill_instr = '0;
  logic issue_valid, issue_nop, pwr_down;
  logic [2:0] issue_tid;
  logic [IW-1:0] issue_instr;

  barrel_issue_sched #(.NT(NT), .DEPTH(DEPTH), .PIPE(PIPE), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .wait_req(wait_req), .resume_req(resume_req), .fill_valid(fill_valid),
    .fill_tid(fill_tid), .fill_instr(fill_instr), .issue_valid(issue_valid),
    .issue_tid(issue_tid), .issue_nop(issue_nop), .issue_instr(issue_instr),
    .pwr_down(pwr_down));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference
  int minuse[NT], mwait[NT], mcool[NT], mcnt[NT], mlast;
  int mbuf[NT][DEPTH];
  bit mlive = 1'b0, e_valid = 1'b0, e_nop = 1'b0, e_pwr = 1'b0;
  int e_tid = 0, e_instr = 0;

  always @(posedge clk) begin
    int s, fid;
    bit acc;
    mlive = 1'b1;
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        minuse[t] = (t == 0); mwait[t] = 0; mcool[t] = 0; mcnt[t] = 0;
      end
      mlast = NT - 1;
      e_valid = 0; e_tid = 0; e_nop = 0; e_instr = 0;
    end else begin
      s = -1;
      for (int k = 1; k <= NT; k++) begin
        int t;
        t = (mlast + k) % NT;
        if (s < 0 && minuse[t] != 0 && mwait[t] == 0 && mcool[t] == 0) s = t;
      end
      e_valid = (s >= 0);
      e_tid   = e_valid ? s : 0;
      e_nop   = e_valid && mcnt[s] == 0;
      e_instr = (e_valid && mcnt[s] > 0) ? mbuf[s][0] : 0;
      fid = int'(fill_tid);
      acc = fill_valid && mcnt[fid] < DEPTH && !start_req[fid];
      for (int t = 0; t < NT; t++) if (mcool[t] > 0) mcool[t]--;
      if (e_valid) begin
        mcool[s] = PIPE - 1;
        mlast = s;
        if (mcnt[s] > 0) begin
          for (int i = 0; i < DEPTH - 1; i++) mbuf[s][i] = mbuf[s][i+1];
          mcnt[s]--;
        end
      end
      if (acc) begin
        mbuf[fid][mcnt[fid]] = int'(fill_instr);
        mcnt[fid]++;
      end
      for (int t = 0; t < NT; t++) begin
        if (start_req[t]) begin minuse[t] = 1; mwait[t] = 0; mcnt[t] = 0; end
        else if (stop_req[t]) begin minuse[t] = 0; mwait[t] = 0; end
        else if (resume_req[t]) mwait[t] = 0;
        else if (wait_req[t] && minuse[t] != 0) mwait[t] = 1;
      end
    end
    e_pwr = 1'b1;
    for (int t = 0; t < NT; t++) if (minuse[t] != 0 && mwait[t] == 0) e_pwr = 1'b0;
  end

  int cyc = 0;
  int icount[NT], ncount[NT];
  int lastiss[NT] = '{default: -1};

  always @(negedge clk) begin
    cyc++;
    if (mlive) begin
      chk(issue_valid == e_valid, "R10 issue_valid", issue_valid, e_valid);
      chk(issue_tid == 3'(e_tid), "R2 issue_tid", issue_tid, e_tid);
      chk(issue_nop == e_nop, "R8 issue_nop", issue_nop, e_nop);
      chk(issue_instr == IW'(e_instr), "R8 issue_instr", issue_instr, e_instr);
      chk(pwr_down == e_pwr, "R11 pwr_down", pwr_down, e_pwr);
    end
    if (rst_n && issue_valid) begin
      icount[issue_tid]++;
      if (!issue_nop) ncount[issue_tid]++;
      if (lastiss[issue_tid] >= 0)
        chk(cyc - lastiss[issue_tid] >= PIPE, "R3 issue spacing", cyc - lastiss[issue_tid], PIPE);
      lastiss[issue_tid] = cyc;
    end
  end

  task automatic do_start(input logic [NT-1:0] m);
    @(negedge clk); start_req = m; @(negedge clk); start_req = '0;
  endtask
  task automatic do_stop(input logic [NT-1:0] m);
    @(negedge clk); stop_req = m; @(negedge clk); stop_req = '0;
  endtask
  task automatic do_wait(input logic [NT-1:0] m);
    @(negedge clk); wait_req = m; @(negedge clk); wait_req = '0;
  endtask
  task automatic do_resume(input logic [NT-1:0] m);
    @(negedge clk); resume_req = m; @(negedge clk); resume_req = '0;
  endtask
  task automatic do_both(input logic [NT-1:0] w, input logic [NT-1:0] r);
    @(negedge clk); wait_req = w; resume_req = r;
    @(negedge clk); wait_req = '0; resume_req = '0;
  endtask
  task automatic do_fill(input int tid, input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fill_valid = 1'b1; fill_tid = 3'(tid); fill_instr = IW'(base + i);
    end
    @(negedge clk); fill_valid = 1'b0;
  endtask
  task automatic window(input int n);
    @(posedge clk);
    for (int t = 0; t < NT; t++) begin icount[t] = 0; ncount[t] = 0; end
    repeat (n) @(posedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!issue_valid && !issue_nop && issue_tid == 0 && issue_instr == 0, "R1 outputs in reset", issue_valid, 0);
    chk(!pwr_down, "R1 pwr_down in reset", pwr_down, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(issue_valid && issue_tid == 0 && issue_nop, "R1 first issue", {issue_valid, issue_tid, issue_nop}, 5'b10001);

    // R5 and R9: park thread 0, overfill, then wake it
    do_wait(8'h01);
    window(4);
    do_fill(0, 6, 16'hA000);
    chk(icount[0] == 0, "R5 parked thread silent", icount[0], 0);
    window(1);
    do_resume(8'h01);
    repeat (40) @(posedge clk);
    chk(ncount[0] == DEPTH, "R9 full FIFO drops extra words", ncount[0], DEPTH);
    chk(icount[0] > DEPTH, "R8 fetch no-op after drain", icount[0], DEPTH + 1);

    // R4: all eight threads running
    do_start(8'hFE);
    do_fill(5, 2, 16'hB000);
    repeat (16) @(posedge clk);
    window(64);
    for (int t = 0; t < NT; t++) chk(icount[t] == 8, "R4 equal share of 8", icount[t], 8);

    do_wait(8'h0C);
    window(32);
    chk(icount[2] == 0 && icount[3] == 0, "R5 waiting threads skipped", icount[2] + icount[3], 0);

    do_both(8'h04, 8'h0C);
    window(32);
    chk(icount[2] > 0, "R6 resume beats wait", icount[2], 1);
    chk(icount[3] > 0, "R6 resumed thread issues", icount[3], 1);

    do_stop(8'hF0);
    repeat (8) @(posedge clk);
    window(32);
    chk(icount[4] + icount[5] + icount[6] + icount[7] == 0, "R7 stopped threads silent",
        icount[4] + icount[5] + icount[6] + icount[7], 0);
    chk(icount[0] == 8, "R4 equal share of 4", icount[0], 8);

    do_wait(8'h0F);
    chk(pwr_down, "R11 all waiting", pwr_down, 1);
    window(16);
    chk(icount[0] + icount[1] + icount[2] + icount[3] == 0, "R10 no issue when idle",
        icount[0] + icount[1] + icount[2] + icount[3], 0);

    do_resume(8'h02);
    chk(!pwr_down, "R11 wake clears request", pwr_down, 0);
    window(16);
    chk(icount[1] == 16 / PIPE, "R3 lone thread paced by pipeline", icount[1], 16 / PIPE);

    do_start(8'h10);
    repeat (4) @(posedge clk);
    window(16);
    chk(icount[4] == 16 / PIPE, "R7 restarted thread issues", icount[4], 16 / PIPE);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule